// File: doc/BRIEF.md
# In-Order Retire Stage with Flush-Younger Barrier

This block is the retire end of a single-thread out-of-order pipeline. It keeps a small circular reorder buffer. Dispatch writes each instruction into the buffer in program order, carrying its sequence number, its address, the address of the instruction that follows it, and a barrier flag. Execution later marks entries complete by sequence number. Retirement takes the oldest entry only, in order, once that entry is complete, and passes it out on a commit stream.

The barrier flag is for instructions whose effect changes how later instructions must be decoded, for example a write to an address-space selector register. When the oldest entry carries this flag, that entry still retires normally. On the next cycle the stage sends a one-cycle flush pulse to the earlier stages. The pulse carries the retired entry's sequence number as the last completed one and its following address as the restart point, and it reports that this is not a branch mispredict. The stage then enters a flushing state. In that state it removes the younger entries from the tail, two per cycle, and it neither retires nor accepts dispatch.

Both data interfaces are valid/ready. A dispatch write happens in a cycle where `dsp_valid` and `dsp_ready` are both high. A retirement happens in a cycle where `cmt_valid` and `cmt_ready` are both high. While `cmt_ready` is low, the commit payload holds steady. The flush outputs are plain control signals with no handshake.

Top module: `rob_commit`

## Requirements
- R1: `cmt_valid` is high only when the buffer is not empty, its oldest entry is marked complete, and the stage is not flushing. Entries retire one per accepted cycle, strictly in dispatch order.
- R2: While `cmt_valid` is high and `cmt_ready` is low, the commit payload stays unchanged and nothing retires.
- R3: A dispatch is accepted when `dsp_valid` and `dsp_ready` are both high. `dsp_ready` is low when all DEPTH (default 8) slots are occupied, and a write offered then is dropped.
- R4: `cpl_valid` with `cpl_seq` marks the buffered entry with that sequence number complete. Marking a younger entry complete does not make an incomplete oldest entry retire.
- R5: An entry whose barrier flag is set appears on the commit port with `cmt_sqa` = 1 and retires like any other entry. `sq_pulse` is high for exactly the one cycle after its retirement.
- R6: During the flush pulse, `sq_done_seq` equals the retired barrier entry's sequence number, `sq_redirect_pc` equals its following address, and `sq_mispredict` is 0.
- R7: `sq_busy` rises together with `sq_pulse` and stays high for max(1, ceil(n/2)) cycles, where n is the number of entries younger than the barrier. While `sq_busy` is high, both `cmt_valid` and `dsp_ready` are low.
- R8: Every entry younger than the barrier is discarded. Afterwards, completing a discarded sequence number retires nothing, and newly dispatched entries retire normally.
- R9: Sequence numbers are SEQ_W bits wide (default 6) and wrap from 63 to 0. Order is decided by wrap-aware subtraction, so retirement and flushing work across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsp_valid | input | 1 | Dispatch write offered |
| dsp_ready | output | 1 | Buffer can accept a dispatch write |
| dsp_seq | input | SEQ_W | Sequence number of dispatched entry |
| dsp_pc | input | PC_W | Address of dispatched instruction |
| dsp_npc | input | PC_W | Address of the instruction after it |
| dsp_sqa | input | 1 | Barrier flag: flush younger entries at retirement |
| cpl_valid | input | 1 | Completion mark strobe |
| cpl_seq | input | SEQ_W | Sequence number being marked complete |
| cmt_valid | output | 1 | Oldest entry ready to retire |
| cmt_ready | input | 1 | Downstream accepts the retirement |
| cmt_seq | output | SEQ_W | Sequence number of retiring entry |
| cmt_pc | output | PC_W | Address of retiring entry |
| cmt_npc | output | PC_W | Following address of retiring entry |
| cmt_sqa | output | 1 | Retiring entry carries the barrier flag |
| sq_pulse | output | 1 | One-cycle flush command to earlier stages |
| sq_busy | output | 1 | Buffer is discarding younger entries |
| sq_mispredict | output | 1 | Flush caused by a mispredict (always 0 here) |
| sq_done_seq | output | SEQ_W | Last completed sequence number for the flush |
| sq_redirect_pc | output | PC_W | Address from which fetch restarts |

## Verification
The bound checker checks these rules on every cycle: the pulse lasts exactly one cycle, the pulse follows every barrier retirement with the right sequence number and restart address, the mispredict flag is low, retirement and dispatch are both blocked while flushing, the payload holds under back-pressure, and retired sequence numbers always move forward in wrap-aware order. Some properties need whole scenarios and are shown only by the bench. These are the flushing-state length for a given number of younger entries, the fact that discarded entries never reach the commit port even after a late completion, the full-buffer refusal, and the order of retirement across the sequence-number wrap.

// File: rtl/rob_commit_pkg.sv
package rob_commit_pkg;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_FLUSH = 1'b1
  } cmt_state_e;

  // Wrap-aware order: a is younger than b when (a - b) mod 2^w lies in 1 .. 2^(w-1)-1.
  function automatic logic seq_younger(input logic [15:0] a, input logic [15:0] b, input int w);
    logic [15:0] diff;
    logic [15:0] mask;
    mask = 16'((32'd1 << w) - 1);
    diff = (a - b) & mask;
    return (diff != 16'd0) && (((diff >> (w - 1)) & 16'd1) == 16'd0);
  endfunction

endpackage

// File: rtl/rob_store.sv
module rob_store #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 6,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEQ_W-1:0] wr_seq,
  input  logic [PC_W-1:0]  wr_pc,
  input  logic [PC_W-1:0]  wr_npc,
  input  logic             wr_sqa,
  input  logic             cpl_en,
  input  logic [SEQ_W-1:0] cpl_seq,
  input  logic             pop_en,
  input  logic [1:0]       trim_n,
  output logic             hd_valid,
  output logic             hd_done,
  output logic [SEQ_W-1:0] hd_seq,
  output logic [PC_W-1:0]  hd_pc,
  output logic [PC_W-1:0]  hd_npc,
  output logic             hd_sqa,
  output logic [CNT_W-1:0] count
);
  // DEPTH must be a power of two so pointers wrap naturally.
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [PC_W-1:0]  pc_q  [DEPTH];
  logic [PC_W-1:0]  npc_q [DEPTH];
  logic [DEPTH-1:0] sqa_q;
  logic [DEPTH-1:0] done_q;
  logic [DEPTH-1:0] cpl_hit;
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_match
      logic [IDX_W-1:0] off;
      assign off = IDX_W'(gi) - head_q;
      assign cpl_hit[gi] = cpl_en && ({1'b0, off} < count_q) && (seq_q[gi] == cpl_seq);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_en) begin
      seq_q[tail_q] <= wr_seq;
      pc_q[tail_q]  <= wr_pc;
      npc_q[tail_q] <= wr_npc;
      sqa_q[tail_q] <= wr_sqa;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && (tail_q == IDX_W'(i))) done_q[i] <= 1'b0;
        else if (cpl_hit[i])                done_q[i] <= 1'b1;
      end
      head_q  <= head_q + IDX_W'(pop_en);
      tail_q  <= tail_q + IDX_W'(wr_en) - IDX_W'(trim_n);
      count_q <= count_q + CNT_W'(wr_en) - CNT_W'(pop_en) - CNT_W'(trim_n);
    end
  end

  assign hd_valid = (count_q != '0);
  assign hd_done  = hd_valid && done_q[head_q];
  assign hd_seq   = seq_q[head_q];
  assign hd_pc    = pc_q[head_q];
  assign hd_npc   = npc_q[head_q];
  assign hd_sqa   = sqa_q[head_q];
  assign count    = count_q;
endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl
  import rob_commit_pkg::*;
#(
  parameter int SEQ_W = 6,
  parameter int PC_W  = 32,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hd_done,
  input  logic             hd_sqa,
  input  logic [SEQ_W-1:0] hd_seq,
  input  logic [PC_W-1:0]  hd_npc,
  input  logic [CNT_W-1:0] count,
  input  logic             cmt_ready,
  output logic             cmt_valid,
  output logic             pop_en,
  output logic [1:0]       trim_n,
  output logic             run,
  output logic             sq_pulse,
  output logic             sq_busy,
  output logic [SEQ_W-1:0] sq_seq,
  output logic [PC_W-1:0]  sq_pc
);
  cmt_state_e state_q;
  logic       fire;

  assign run       = (state_q == ST_RUN);
  assign cmt_valid = run && hd_done;
  assign fire      = cmt_valid && cmt_ready;
  assign pop_en    = fire;
  assign sq_busy   = (state_q == ST_FLUSH);

  always_comb begin
    trim_n = 2'd0;
    if (sq_busy) trim_n = (count >= CNT_W'(2)) ? 2'd2 : count[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      sq_pulse <= 1'b0;
      sq_seq   <= '0;
      sq_pc    <= '0;
    end else begin
      sq_pulse <= 1'b0;
      if (fire && hd_sqa) begin
        state_q  <= ST_FLUSH;
        sq_pulse <= 1'b1;
        sq_seq   <= hd_seq;
        sq_pc    <= hd_npc;
      end else if (sq_busy && (count <= CNT_W'(2))) begin
        state_q <= ST_RUN;
      end
    end
  end
endmodule

// File: rtl/rob_commit.sv
module rob_commit #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 6,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dsp_valid,
  output logic             dsp_ready,
  input  logic [SEQ_W-1:0] dsp_seq,
  input  logic [PC_W-1:0]  dsp_pc,
  input  logic [PC_W-1:0]  dsp_npc,
  input  logic             dsp_sqa,
  input  logic             cpl_valid,
  input  logic [SEQ_W-1:0] cpl_seq,
  output logic             cmt_valid,
  input  logic             cmt_ready,
  output logic [SEQ_W-1:0] cmt_seq,
  output logic [PC_W-1:0]  cmt_pc,
  output logic [PC_W-1:0]  cmt_npc,
  output logic             cmt_sqa,
  output logic             sq_pulse,
  output logic             sq_busy,
  output logic             sq_mispredict,
  output logic [SEQ_W-1:0] sq_done_seq,
  output logic [PC_W-1:0]  sq_redirect_pc
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = IDX_W + 1;

  logic             wr_en, pop_en, run, hd_valid, hd_done;
  logic [1:0]       trim_n;
  logic [CNT_W-1:0] count;

  assign dsp_ready     = run && (count < CNT_W'(DEPTH));
  assign wr_en         = dsp_valid && dsp_ready;
  assign sq_mispredict = 1'b0;

  rob_store #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_seq(dsp_seq), .wr_pc(dsp_pc), .wr_npc(dsp_npc), .wr_sqa(dsp_sqa),
    .cpl_en(cpl_valid), .cpl_seq(cpl_seq),
    .pop_en(pop_en), .trim_n(trim_n),
    .hd_valid(hd_valid), .hd_done(hd_done), .hd_seq(cmt_seq), .hd_pc(cmt_pc),
    .hd_npc(cmt_npc), .hd_sqa(cmt_sqa), .count(count)
  );

  commit_ctrl #(.SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .hd_done(hd_done), .hd_sqa(cmt_sqa), .hd_seq(cmt_seq), .hd_npc(cmt_npc),
    .count(count), .cmt_ready(cmt_ready),
    .cmt_valid(cmt_valid), .pop_en(pop_en), .trim_n(trim_n), .run(run),
    .sq_pulse(sq_pulse), .sq_busy(sq_busy), .sq_seq(sq_done_seq), .sq_pc(sq_redirect_pc)
  );
endmodule

// File: rtl/rob_commit_chk.sv
module rob_commit_chk
  import rob_commit_pkg::*;
#(
  parameter int SEQ_W = 6,
  parameter int PC_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dsp_ready,
  input logic             cmt_valid,
  input logic             cmt_ready,
  input logic [SEQ_W-1:0] cmt_seq,
  input logic [PC_W-1:0]  cmt_npc,
  input logic             cmt_sqa,
  input logic             sq_pulse,
  input logic             sq_busy,
  input logic             sq_mispredict,
  input logic [SEQ_W-1:0] sq_done_seq,
  input logic [PC_W-1:0]  sq_redirect_pc
);
  logic             have_prev;
  logic [SEQ_W-1:0] prev_seq;
  logic             fire;

  assign fire = cmt_valid && cmt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_seq  <= '0;
    end else if (fire) begin
      have_prev <= 1'b1;
      prev_seq  <= cmt_seq;
    end
  end

  AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && have_prev) |-> seq_younger(16'(cmt_seq), 16'(prev_seq), SEQ_W)); // R9
  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !cmt_ready) |=> (cmt_valid && $stable(cmt_seq) && $stable(cmt_npc))); // R2
  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmt_sqa) |=> sq_pulse); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sq_pulse |=> !sq_pulse); // R5
  AST_FLUSH_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmt_sqa) |=> (sq_done_seq == $past(cmt_seq) && sq_redirect_pc == $past(cmt_npc))); // R6
  AST_NOT_MISPRED: assert property (@(posedge clk) disable iff (!rst_n)
    sq_pulse |-> !sq_mispredict); // R6
  AST_BUSY_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sq_pulse |-> sq_busy); // R7
  AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    sq_busy |-> (!cmt_valid && !dsp_ready)); // R7
endmodule

bind rob_commit rob_commit_chk #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_chk (.*);

// File: tb/rob_commit_tb.sv
module rob_commit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SEQ_W = 6;
  localparam int PC_W  = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dsp_valid = 1'b0;
  logic             dsp_ready;
  logic [SEQ_W-1:0] dsp_seq = '0;
  logic [PC_W-1:0]  dsp_pc = '0;
  logic [PC_W-1:0]  dsp_npc = '0;
  logic             dsp_sqa = 1'b0;
  logic             cpl_valid = 1'b0;
  logic [SEQ_W-1:0] cpl_seq = '0;
  logic             cmt_valid;
  logic             cmt_ready = 1'b0;
  logic [SEQ_W-1:0] cmt_seq;
  logic [PC_W-1:0]  cmt_pc, cmt_npc;
  logic             cmt_sqa;
  logic             sq_pulse, sq_busy, sq_mispredict;
  logic [SEQ_W-1:0] sq_done_seq;
  logic [PC_W-1:0]  sq_redirect_pc;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_commit #(.DEPTH(8), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_dut (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic disp(input int seq, input logic sqa);
    dsp_valid = 1'b1;
    dsp_seq   = SEQ_W'(seq);
    dsp_pc    = PC_W'(32'h1000 + seq * 4);
    dsp_npc   = PC_W'(32'h1000 + seq * 4 + 4);
    dsp_sqa   = sqa;
    tick();
    dsp_valid = 1'b0;
    dsp_sqa   = 1'b0;
  endtask

  task automatic cpl(input int seq);
    cpl_valid = 1'b1;
    cpl_seq   = SEQ_W'(seq);
    tick();
    cpl_valid = 1'b0;
  endtask

  task automatic drain(input int first, input int n, input string req);
    cmt_ready = 1'b1;
    for (int k = 0; k < n; k++) begin
      chk({req, " valid"}, 64'(cmt_valid), 64'd1);
      chk({req, " seq"}, 64'(cmt_seq), 64'((first + k) % 64));
      tick();
    end
    cmt_ready = 1'b0;
  endtask

  // Retire a ready barrier entry, then count the cycles the flush state lasts.
  task automatic fire_barrier(input int seq, input int exp_busy);
    int  busy_cycles;
    logic extra_pulse;
    chk("R5 barrier on commit port", 64'({cmt_valid, cmt_sqa}), 64'b11);
    chk("R5 barrier seq", 64'(cmt_seq), 64'(seq));
    cmt_ready = 1'b1;
    tick();
    cmt_ready = 1'b0;
    chk("R5 pulse", 64'(sq_pulse), 64'd1);
    chk("R6 done seq", 64'(sq_done_seq), 64'(seq));
    chk("R6 redirect", 64'(sq_redirect_pc), 64'(32'h1000 + seq * 4 + 4));
    chk("R6 mispredict", 64'(sq_mispredict), 64'd0);
    chk("R7 blocks", 64'({cmt_valid, dsp_ready}), 64'b00);
    busy_cycles = 0;
    extra_pulse = 1'b0;
    while (sq_busy && busy_cycles < 20) begin
      if (busy_cycles > 0 && sq_pulse) extra_pulse = 1'b1;
      busy_cycles++;
      tick();
    end
    chk("R5 pulse one cycle", 64'(extra_pulse), 64'd0);
    chk("R7 busy length", 64'(busy_cycles), 64'(exp_busy));
    chk("R7 dispatch reopens", 64'(dsp_ready), 64'd1);
  endtask

  task automatic t_reset();
    chk("R1 reset cmt_valid", 64'(cmt_valid), 64'd0);
    chk("R3 reset dsp_ready", 64'(dsp_ready), 64'd1);
    chk("R5 reset pulse", 64'({sq_pulse, sq_busy}), 64'd0);
  endtask

  task automatic t_inorder();
    disp(1, 0); disp(2, 0); disp(3, 0);
    chk("R4 none complete", 64'(cmt_valid), 64'd0);
    cpl(2);
    chk("R4 younger complete only", 64'(cmt_valid), 64'd0);
    cpl(1);
    chk("R1 head ready", 64'(cmt_valid), 64'd1);
    chk("R1 head pc", 64'(cmt_pc), 64'(32'h1004));
    cpl(3);
    drain(1, 3, "R1 in order");
    chk("R1 empty after drain", 64'(cmt_valid), 64'd0);
  endtask

  task automatic t_backpressure();
    disp(4, 0);
    cpl(4);
    tick(); tick(); tick();
    chk("R2 held valid", 64'(cmt_valid), 64'd1);
    chk("R2 held seq", 64'(cmt_seq), 64'd4);
    drain(4, 1, "R2 release");
    chk("R2 retired once", 64'(cmt_valid), 64'd0);
  endtask

  task automatic t_flush_five();
    disp(10, 1);
    for (int s = 11; s <= 15; s++) disp(s, 0);
    cpl(12);
    cpl(10);
    fire_barrier(10, 3);
    chk("R8 younger discarded", 64'(cmt_valid), 64'd0);
    cpl(11);
    chk("R8 late completion ignored", 64'(cmt_valid), 64'd0);
    disp(16, 0);
    cpl(16);
    drain(16, 1, "R8 new entry retires");
  endtask

  task automatic t_flush_alone();
    disp(17, 1);
    cpl(17);
    fire_barrier(17, 1);
    chk("R8 empty after lone barrier", 64'(cmt_valid), 64'd0);
  endtask

  task automatic t_full();
    for (int s = 40; s <= 47; s++) disp(s, 0);
    chk("R3 full blocks dispatch", 64'(dsp_ready), 64'd0);
    disp(48, 0);
    for (int s = 40; s <= 48; s++) cpl(s);
    drain(40, 8, "R3 eight retire");
    chk("R3 ninth write dropped", 64'(cmt_valid), 64'd0);
  endtask

  task automatic t_wrap();
    disp(62, 0); disp(63, 0); disp(0, 0); disp(1, 0);
    cpl(0); cpl(1); cpl(63); cpl(62);
    drain(62, 4, "R9 wrap order");
    disp(2, 1); disp(3, 0); disp(4, 0); disp(5, 0);
    cpl(2);
    fire_barrier(2, 2);
    chk("R9 flush after wrap empties", 64'(cmt_valid), 64'd0);
    disp(6, 0);
    cpl(6);
    drain(6, 1, "R9 resume after wrap");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_inorder();
    t_backpressure();
    t_flush_five();
    t_flush_alone();
    t_full();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule